// File: doc/BRIEF.md
# Serial Unit Mode and Status Register

This block is the byte-wide control and status register of a serial unit that runs either as an SPI port or as a UART. Software reads and writes it over a simple strobed register bus. Its upper three bits are plain read/write configuration: the operating mode, the UART receiver enable and the SPI role. The block drives these bits straight out to the serial engines.

The middle four bits are sticky status flags. The serial engines set them with single-cycle event pulses: framing error, parity error, byte received and byte sent. Software clears them by writing zero, and each flag also has its own automatic clearing path. Both error flags clear when the register is read. The receive flag clears when the data buffer is read. Writing zero to the receive flag also asks the buffer to drop the byte it holds.

The lowest bit is a read-only busy indicator. It comes from the engine, except in SPI slave mode, where it follows the slave-select level.

Top module: `dcs_top`

## Requirements
- R1: After a synchronous reset, `cfg_uart_mode`, `cfg_rx_en`, `cfg_spi_slave`, `rx_discard` and `reg_rdata` are all 0, and the register reads 0x00 while `eng_busy` is low.
- R2: A write takes bits 7, 6 and 5 of `reg_wdata` as the mode (1 = UART, 0 = SPI), the receiver enable and the SPI role (1 = slave). These bits read back at the same positions and appear on `cfg_uart_mode`, `cfg_rx_en` and `cfg_spi_slave` in the cycle after the write edge.
- R3: Bit 4 (framing error) and bit 3 (parity error) are set by `ev_frame_err` and `ev_parity_err`. A register read returns them and then clears both.
- R4: Bit 2 (byte received) is set by `ev_rx_byte` only in UART mode or in SPI slave mode; in SPI master mode the event is ignored. A `dbuf_rd` pulse clears the bit.
- R5: A write with bit 2 at 0 that takes bit 2 from 1 to 0 raises `rx_discard` for exactly one cycle after the write edge. A zero write while bit 2 is already 0 leaves `rx_discard` low.
- R6: Bit 1 (byte sent) is set by `ev_tx_done` only in UART mode or in SPI master mode; in SPI slave mode the event is ignored.
- R7: For bits 4 to 1, a written 0 clears the flag and a written 1 has no effect.
- R8: When a set event and any clear (write 0, register read or buffer read) reach a flag at the same edge, the flag ends set.
- R9: Bit 0 reads as `spi_ss_lvl` in SPI slave mode (bit 7 = 0, bit 5 = 1) and as `eng_busy` otherwise. Writes to bit 0 have no effect.
- R10: `reg_rdata` is loaded only at an edge where `reg_rd` is high. It shows the register value from before that edge and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| dbuf_rd | input | 1 | Data buffer read strobe |
| ev_frame_err | input | 1 | Engine pulse: bad stop-bit level |
| ev_parity_err | input | 1 | Engine pulse: bad parity |
| ev_rx_byte | input | 1 | Engine pulse: byte received |
| ev_tx_done | input | 1 | Engine pulse: byte fully sent |
| eng_busy | input | 1 | Engine busy level |
| spi_ss_lvl | input | 1 | SPI slave-select level |
| cfg_uart_mode | output | 1 | 1 = UART, 0 = SPI |
| cfg_rx_en | output | 1 | UART receiver enable |
| cfg_spi_slave | output | 1 | 1 = SPI slave, 0 = SPI master |
| rx_discard | output | 1 | One-cycle request to drop the buffered byte |

## Verification
Every stateful result is due one edge after its cause:
- configuration outputs and flags change at the edge that samples a write or an event;
- `reg_rdata` shows the register as it stood just before the read edge;
- `rx_discard` rises at the write edge and falls one edge later.

The bench drives on the falling edge and samples on the next falling edge. Every check therefore looks exactly one rising edge after its stimulus. Each table entry spends one cycle on stimulus and one on a read, so a flag that clears on read is already observed in its cleared state by the following entry.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int REG_W   = 8;
  localparam int NFLAG   = 4;
  // bit positions software decodes
  localparam int B_MODE  = 7;
  localparam int B_RXEN  = 6;
  localparam int B_SLV   = 5;
  localparam int B_FERR  = 4;
  localparam int B_PERR  = 3;
  localparam int B_RXRDY = 2;
  localparam int B_TXDN  = 1;
  localparam int B_BUSY  = 0;
  localparam int FLAG_LO = B_TXDN;
  localparam int CFG_W   = 3;
  // flag index k maps to bit FLAG_LO+k
  localparam logic [NFLAG-1:0] RD_CLR_MASK  = 4'b1100;
  localparam logic [NFLAG-1:0] BUF_CLR_MASK = 4'b0010;
  localparam int K_RX = B_RXRDY - FLAG_LO;

  typedef struct packed {
    logic uart_mode;
    logic rx_en;
    logic spi_slave;
  } cfg_t;
endpackage

// File: rtl/dcs_cfg_bits.sv
module dcs_cfg_bits
  import dcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wbits,
  output cfg_t             cfg
);
  always_ff @(posedge clk) begin
    if (rst) cfg <= '0;
    else if (wr_en) cfg <= cfg_t'(wbits);
  end

  // R2
  cfg_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (cfg == cfg_t'($past(wbits))));
  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cfg));
endmodule

// File: rtl/dcs_flag.sv
module dcs_flag #(
  parameter bit CLR_ON_RD  = 1'b0,
  parameter bit CLR_ON_BUF = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_ev,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic rd_stb,
  input  logic buf_rd,
  output logic q,
  output logic wr_drop
);
  logic clr;

  always_comb begin
    clr = wr_en & ~wr_bit;
    if (CLR_ON_RD)  clr = clr | rd_stb;
    if (CLR_ON_BUF) clr = clr | buf_rd;
  end

  assign wr_drop = wr_en & ~wr_bit & q & ~set_ev;

  always_ff @(posedge clk) begin
    if (rst)         q <= 1'b0;
    else if (set_ev) q <= 1'b1;
    else if (clr)    q <= 1'b0;
  end

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_ev |=> q);
  // R7
  wr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_bit && !set_ev) |=> !q);
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!set_ev && !wr_en && !rd_stb && !buf_rd) |=> $stable(q));
endmodule

// File: rtl/dcs_busy_sel.sv
module dcs_busy_sel (
  input  logic uart_mode,
  input  logic spi_slave,
  input  logic eng_busy,
  input  logic ss_lvl,
  output logic busy
);
  always_comb begin
    if (!uart_mode && spi_slave) busy = ss_lvl;
    else                         busy = eng_busy;
  end
endmodule

// File: rtl/dcs_top.sv
module dcs_top
  import dcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             dbuf_rd,
  input  logic             ev_frame_err,
  input  logic             ev_parity_err,
  input  logic             ev_rx_byte,
  input  logic             ev_tx_done,
  input  logic             eng_busy,
  input  logic             spi_ss_lvl,
  output logic             cfg_uart_mode,
  output logic             cfg_rx_en,
  output logic             cfg_spi_slave,
  output logic             rx_discard
);
  cfg_t             cfg;
  logic [NFLAG-1:0] set_vec;
  logic [NFLAG-1:0] flag_q;
  logic [NFLAG-1:0] drop_vec;
  logic             busy;
  logic             rx_ok;
  logic             tx_ok;
  logic [REG_W-1:0] cur_val;

  dcs_cfg_bits u_cfg (
    .clk   (clk),
    .rst   (rst),
    .wr_en (reg_wr),
    .wbits (reg_wdata[B_MODE:B_SLV]),
    .cfg   (cfg)
  );

  // receive counts in UART or SPI slave, transmit in UART or SPI master
  assign rx_ok   = cfg.uart_mode | cfg.spi_slave;
  assign tx_ok   = cfg.uart_mode | ~cfg.spi_slave;
  assign set_vec = {ev_frame_err, ev_parity_err, ev_rx_byte & rx_ok, ev_tx_done & tx_ok};

  for (genvar k = 0; k < NFLAG; k++) begin : g_flag
    dcs_flag #(
      .CLR_ON_RD  (RD_CLR_MASK[k]),
      .CLR_ON_BUF (BUF_CLR_MASK[k])
    ) u_flag (
      .clk     (clk),
      .rst     (rst),
      .set_ev  (set_vec[k]),
      .wr_en   (reg_wr),
      .wr_bit  (reg_wdata[FLAG_LO+k]),
      .rd_stb  (reg_rd),
      .buf_rd  (dbuf_rd),
      .q       (flag_q[k]),
      .wr_drop (drop_vec[k])
    );
  end

  dcs_busy_sel u_busy (
    .uart_mode (cfg.uart_mode),
    .spi_slave (cfg.spi_slave),
    .eng_busy  (eng_busy),
    .ss_lvl    (spi_ss_lvl),
    .busy      (busy)
  );

  assign cur_val = {cfg, flag_q, busy};

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      rx_discard <= 1'b0;
    end else begin
      if (reg_rd) reg_rdata <= cur_val;
      rx_discard <= drop_vec[K_RX];
    end
  end

  assign cfg_uart_mode = cfg.uart_mode;
  assign cfg_rx_en     = cfg.rx_en;
  assign cfg_spi_slave = cfg.spi_slave;

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));
  // R5
  discard_clears_chk: assert property (@(posedge clk) disable iff (rst)
    rx_discard |-> !flag_q[K_RX]);
  // R5
  discard_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_discard |=> !rx_discard);
  // R9
  ss_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !cfg.uart_mode && cfg.spi_slave) |=> (reg_rdata[B_BUSY] == $past(spi_ss_lvl)));
  // R3
  err_rd_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !ev_frame_err) |=> !flag_q[B_FERR-FLAG_LO]);
endmodule

// File: tb/sim_dcs_top.sv
`timescale 1ns/1ps
module sim_dcs_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0, reg_rd = 1'b0, dbuf_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       ev_fe = 1'b0, ev_pe = 1'b0, ev_rx = 1'b0, ev_tx = 1'b0;
  logic       eng_busy = 1'b0, ss = 1'b0;
  logic       c_mode, c_rxen, c_slv, rx_discard;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  dcs_top u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dbuf_rd(dbuf_rd),
    .ev_frame_err(ev_fe), .ev_parity_err(ev_pe), .ev_rx_byte(ev_rx),
    .ev_tx_done(ev_tx), .eng_busy(eng_busy), .spi_ss_lvl(ss),
    .cfg_uart_mode(c_mode), .cfg_rx_en(c_rxen), .cfg_spi_slave(c_slv),
    .rx_discard(rx_discard)
  );

  // {wr, wdata[8], events fe pe rx tx, busy, ss, expected read}
  localparam int NV = 13;
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 8'h00, 4'b0000, 1'b0, 1'b0, 8'h00},
    {1'b1, 8'hE0, 4'b0000, 1'b1, 1'b0, 8'hE1},
    {1'b0, 8'h00, 4'b1111, 1'b0, 1'b0, 8'hFE},
    {1'b0, 8'h00, 4'b0000, 1'b0, 1'b0, 8'hE6},
    {1'b1, 8'hFF, 4'b0000, 1'b0, 1'b0, 8'hE6},
    {1'b1, 8'hE2, 4'b0000, 1'b0, 1'b0, 8'hE2},
    {1'b1, 8'hE0, 4'b0000, 1'b0, 1'b0, 8'hE0},
    {1'b1, 8'h20, 4'b0000, 1'b0, 1'b1, 8'h21},
    {1'b0, 8'h00, 4'b0011, 1'b0, 1'b0, 8'h24},
    {1'b1, 8'h00, 4'b0000, 1'b1, 1'b1, 8'h01},
    {1'b0, 8'h00, 4'b0011, 1'b0, 1'b0, 8'h02},
    {1'b0, 8'h00, 4'b1000, 1'b0, 1'b0, 8'h12},
    {1'b0, 8'h00, 4'b0000, 1'b0, 1'b0, 8'h02}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    reg_wr = 0; reg_rd = 0; dbuf_rd = 0;
    ev_fe = 0; ev_pe = 0; ev_rx = 0; ev_tx = 0;
  endtask

  task automatic do_write(input logic [7:0] d);
    reg_wr = 1; reg_wdata = d; tick(); quiet();
  endtask

  task automatic do_read(input string tag, input logic [7:0] exp);
    reg_rd = 1; tick(); quiet(); chk(tag, reg_rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk); tick(); tick();
    rst = 0;
    // R1 reset state
    chk("R1 cfg outputs", {5'd0, c_mode, c_rxen, c_slv}, 8'h00);
    chk("R1 rdata", reg_rdata, 8'h00);
    chk("R1 rx_discard", {7'd0, rx_discard}, 8'h00);
    do_read("R1 register value", 8'h00);

    // table: R2 R3 R4 R6 R7 R9 R10
    for (int i = 0; i < NV; i++) begin
      reg_wr = VEC[i][22]; reg_wdata = VEC[i][21:14];
      {ev_fe, ev_pe, ev_rx, ev_tx} = VEC[i][13:10];
      eng_busy = VEC[i][9]; ss = VEC[i][8];
      tick(); quiet();
      reg_rd = 1; tick(); quiet();
      chk($sformatf("table vec %0d (R2 R3 R4 R6 R7 R9)", i), reg_rdata, VEC[i][7:0]);
    end
    eng_busy = 0; ss = 0;

    // R2 configuration outputs one cycle after write
    reg_wr = 1; reg_wdata = 8'hA0; tick(); quiet();
    chk("R2 cfg outputs", {5'd0, c_mode, c_rxen, c_slv}, 8'h05);

    // R10 rdata holds without read
    do_write(8'h80);
    do_read("R10 baseline", 8'h80);
    ev_pe = 1; tick(); quiet();
    chk("R10 hold without read", reg_rdata, 8'h80);
    do_read("R10 after read", 8'h88);

    // R8 write-zero together with tx event
    reg_wr = 1; reg_wdata = 8'h80; ev_tx = 1; tick(); quiet();
    do_read("R8 tx set beats write 0", 8'h82);
    // R8 read together with frame error event
    reg_rd = 1; ev_fe = 1; tick(); quiet();
    chk("R8 read returns pre-event", reg_rdata, 8'h82);
    do_read("R8 fe survives read", 8'h92);

    // R4 buffer read clears rx flag; R8 with simultaneous rx event
    ev_rx = 1; tick(); quiet();
    do_read("R4 rx set in UART", 8'h86);
    dbuf_rd = 1; tick(); quiet();
    do_read("R4 dbuf_rd clears rx", 8'h82);
    ev_rx = 1; tick(); quiet();
    dbuf_rd = 1; ev_rx = 1; tick(); quiet();
    do_read("R8 rx set beats dbuf_rd", 8'h86);

    // R5 discard pulse timing
    reg_wr = 1; reg_wdata = 8'h82; tick(); quiet();
    chk("R5 discard pulse high", {7'd0, rx_discard}, 8'h01);
    tick();
    chk("R5 discard pulse one cycle", {7'd0, rx_discard}, 8'h00);
    reg_wr = 1; reg_wdata = 8'h80; tick(); quiet();
    chk("R5 no pulse when already clear", {7'd0, rx_discard}, 8'h00);

    // R6 tx ignored in SPI slave; R9 busy follows ss in slave
    do_write(8'h20);
    ev_tx = 1; eng_busy = 1; ss = 0; tick(); quiet();
    do_read("R6 tx ignored in SPI slave, R9 ss low", 8'h20);
    // R4 rx ignored in SPI master
    do_write(8'h00);
    ev_rx = 1; tick(); quiet();
    do_read("R4 rx ignored in SPI master, R9 busy", 8'h01);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule